// File: doc/BRIEF.md
# Streaming Page ECC Generator

This block computes Hamming-style check codes over a stream of bytes while the bytes pass by, without storing the data. Each accepted byte updates a set of parity accumulators. Line parities track the byte's position in the block. Column parities track the bit positions inside the byte. When a block of bytes is complete, the block packs the accumulators into a 24-bit code and latches the code into a result register. The stored codes let a later reader correct any single flipped bit in the block and detect any two flipped bits.

Two block layouts are available. In split mode, two codes are produced: the first covers bytes 0–255 and the second covers bytes 256–511. In whole mode, one code covers all 512 bytes. Software pulses a rearm strobe before each page. This clears the results and the byte count. Once the final code is done, the results and the done flag hold until the next rearm, however many more bytes arrive. The data path is one byte wide.

Top module: `ecc_stream_gen`

## Requirements
- R1: With the mode latched at 0 (split), `ecc1` loads the code of bytes 0–255 in the clock edge that accepts byte 255. `ecc2` loads the code of bytes 256–511 in the edge that accepts byte 511.
- R2: With the mode latched at 1 (whole), `ecc1` loads the code of bytes 0–511 in the edge that accepts byte 511. `ecc2` keeps the all-ones value.
- R3: A rearm pulse clears the state in the next edge: `done` goes low, `ecc1` and `ecc2` become all ones, and the byte count returns to 0. A byte presented in the same cycle as rearm is discarded.
- R4: While `done` is high, accepted-looking bytes change neither `ecc1`, `ecc2` nor `done`.
- R5: `done` rises in the edge that accepts byte 511, so it is visible in the cycle after the last byte. It stays high until rearm or reset.
- R6: Split code layout: bit 2k is the inverted XOR of the byte parities of the bytes whose in-block index has bit k = 0, and bit 2k+1 covers the bytes with index bit k = 1, for k = 0..7. Bits 16..21 are the inverted column parities C0..C5. Bits 22..23 are 1. Column group Cj, with L = j/2, XORs the data bits whose position has bit L equal to j mod 2 (C0 = bits 0,2,4,6; C1 = 1,3,5,7; C2 = 0,1,4,5; C3 = 2,3,6,7; C4 = 0..3; C5 = 4..7), over every byte of the block.
- R7: Whole code layout: the same line-pair rule for k = 0..8 fills bits 0..17, and C0..C5 fill bits 18..23.
- R8: A block of all-0xFF bytes gives an all-ones code.
- R9: Flipping one data bit changes exactly one bit of every line pair and every column pair of the affected code. That is 11 bits in split mode and 12 bits in whole mode.
- R10: The mode input is sampled with the first accepted byte after rearm. Later changes have no effect until the next rearm.
- R11: After reset, `done` is low and both result registers are all ones.
- R12: Cycles with `in_valid` low are not counted. The codes do not depend on idle gaps between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Data byte |
| mode_whole | input | 1 | 0 = two 256-byte codes, 1 = one 512-byte code |
| rearm | input | 1 | Clears results and restarts byte counting |
| ecc1 | output | 24 | First (or only) code |
| ecc2 | output | 24 | Second code in split mode |
| done | output | 1 | Final code complete |

## Verification
The bench checks `ecc1` right after byte 255 in split mode. A design that cleared the line accumulators one byte late, or sampled the result before the last byte was folded in, would show a wrong first code there. It checks that `done` stays low after 511 bytes and rises after byte 512, which catches an off-by-one in the terminal count. It feeds extra bytes after completion, switches the mode in the middle of a run, and presents a byte in the same cycle as rearm. A design that kept accumulating, re-sampled the mode, or counted the rearm byte would produce codes that differ from the model. Single-bit flips are checked by counting the changed code bits, which exposes a mis-paired line or column group.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;

    localparam int BYTE_W   = 8;
    localparam int COL_BITS = 6;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_WHOLE = 1'b1
    } ecc_mode_e;

    // Column group j tests bit (j/2) of the bit position against (j%2).
    function automatic logic [COL_BITS-1:0] col_parity(input logic [BYTE_W-1:0] b);
        logic [COL_BITS-1:0] acc;
        acc = '0;
        for (int j = 0; j < COL_BITS; j++) begin
            for (int p = 0; p < BYTE_W; p++) begin
                if (((p >> (j / 2)) & 1) == (j % 2)) begin
                    acc[j] = acc[j] ^ b[p];
                end
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecc_line_acc.sv
module ecc_line_acc #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             clear,
    input  logic [IDX_W-1:0] idx,
    input  logic             bit_par,
    output logic [IDX_W-1:0] hi_sum,
    output logic [IDX_W-1:0] lo_sum
);

    typedef struct packed {
        logic [IDX_W-1:0] hi;
        logic [IDX_W-1:0] lo;
    } line_t;

    line_t s_d, s_q;

    always_comb begin
        for (int k = 0; k < IDX_W; k++) begin
            hi_sum[k] = s_q.hi[k] ^ (take & bit_par & idx[k]);
            lo_sum[k] = s_q.lo[k] ^ (take & bit_par & ~idx[k]);
        end
        if (clear) begin
            s_d = '0;
        end else begin
            s_d.hi = hi_sum;
            s_d.lo = lo_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc
    import ecc_stream_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                clear,
    input  logic [BYTE_W-1:0]   data,
    output logic [COL_BITS-1:0] col_sum
);

    typedef struct packed {
        logic [COL_BITS-1:0] col;
    } col_t;

    col_t s_d, s_q;

    always_comb begin
        col_sum = s_q.col ^ (take ? col_parity(data) : '0);
        s_d.col = clear ? '0 : col_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
    import ecc_stream_pkg::*;
#(
    parameter int SUB_IDX_W  = 8,
    parameter int FULL_IDX_W = SUB_IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  rearm,
    input  logic                  mode_in,
    output logic                  take,
    output logic [FULL_IDX_W-1:0] idx,
    output ecc_mode_e             eff_mode,
    output logic                  end_first,
    output logic                  end_final,
    output logic                  done
);

    typedef struct packed {
        logic [FULL_IDX_W-1:0] cnt;
        ecc_mode_e             mode;
        logic                  done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        take      = in_valid & ~s_q.done & ~rearm;
        idx       = s_q.cnt;
        eff_mode  = (s_q.cnt == '0) ? ecc_mode_e'(mode_in) : s_q.mode;
        end_first = take & (eff_mode == MODE_SPLIT) & ~s_q.cnt[FULL_IDX_W-1]
                    & (&s_q.cnt[SUB_IDX_W-1:0]);
        end_final = take & (&s_q.cnt);
        done      = s_q.done;

        s_d = s_q;
        if (rearm) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (take) begin
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.mode = eff_mode;
            s_d.done = end_final;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, mode: MODE_SPLIT, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_stream_pkg::*;
#(
    parameter  int SUB_IDX_W  = 8,
    localparam int FULL_IDX_W = SUB_IDX_W + 1,
    localparam int CODE_W     = 2 * FULL_IDX_W + COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              mode_whole,
    input  logic              rearm,
    output logic [CODE_W-1:0] ecc1,
    output logic [CODE_W-1:0] ecc2,
    output logic              done
);

    logic                  take;
    logic [FULL_IDX_W-1:0] idx;
    ecc_mode_e             eff_mode;
    logic                  end_first;
    logic                  end_final;
    logic                  blk_clear;
    logic [FULL_IDX_W-1:0] hi_sum;
    logic [FULL_IDX_W-1:0] lo_sum;
    logic [COL_BITS-1:0]   col_sum;
    logic [CODE_W-1:0]     split_code;
    logic [CODE_W-1:0]     whole_code;

    ecc_ctrl #(
        .SUB_IDX_W (SUB_IDX_W),
        .FULL_IDX_W(FULL_IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .rearm    (rearm),
        .mode_in  (mode_whole),
        .take     (take),
        .idx      (idx),
        .eff_mode (eff_mode),
        .end_first(end_first),
        .end_final(end_final),
        .done     (done)
    );

    assign blk_clear = rearm | end_first | end_final;

    ecc_line_acc #(
        .IDX_W(FULL_IDX_W)
    ) line_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .clear  (blk_clear),
        .idx    (idx),
        .bit_par(^in_byte),
        .hi_sum (hi_sum),
        .lo_sum (lo_sum)
    );

    ecc_col_acc col_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .clear  (blk_clear),
        .data   (in_byte),
        .col_sum(col_sum)
    );

    // Code packing: line pairs low, column parity above, spare bits high.
    generate
        for (genvar b = 0; b < CODE_W; b++) begin : g_pack
            if (b < 2 * SUB_IDX_W) begin : g_sl
                assign split_code[b] = (b % 2 == 0) ? ~lo_sum[b/2] : ~hi_sum[b/2];
            end else if (b < 2 * SUB_IDX_W + COL_BITS) begin : g_sc
                assign split_code[b] = ~col_sum[b - 2*SUB_IDX_W];
            end else begin : g_ss
                assign split_code[b] = 1'b1;
            end
            if (b < 2 * FULL_IDX_W) begin : g_wl
                assign whole_code[b] = (b % 2 == 0) ? ~lo_sum[b/2] : ~hi_sum[b/2];
            end else begin : g_wc
                assign whole_code[b] = ~col_sum[b - 2*FULL_IDX_W];
            end
        end
    endgenerate

    typedef struct packed {
        logic [CODE_W-1:0] r1;
        logic [CODE_W-1:0] r2;
    } res_t;

    res_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rearm) begin
            s_d.r1 = '1;
            s_d.r2 = '1;
        end else begin
            if (end_first) begin
                s_d.r1 = split_code;
            end
            if (end_final) begin
                if (eff_mode == MODE_SPLIT) begin
                    s_d.r2 = split_code;
                end else begin
                    s_d.r1 = whole_code;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{r1: '1, r2: '1};
        end else begin
            s_q <= s_d;
        end
    end

    assign ecc1 = s_q.r1;
    assign ecc2 = s_q.r2;

endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk #(
    parameter int FULL_IDX_W = 9,
    parameter int CODE_W     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              rearm,
    input logic [CODE_W-1:0] ecc1,
    input logic [CODE_W-1:0] ecc2,
    input logic              done
);

    localparam int PAGE = 1 << FULL_IDX_W;

    logic [FULL_IDX_W:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (rearm) begin
            seen_q <= '0;
        end else if (in_valid && !done) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    p_rearm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!done && (ecc1 == '1) && (ecc2 == '1)));

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rearm) |=> (done && $stable(ecc1) && $stable(ecc2)));

    p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (seen_q == PAGE[FULL_IDX_W:0]));

    p_ecc2_final_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ecc2) |-> (done || $past(rearm)));

    p_no_early_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q < PAGE[FULL_IDX_W:0] - 1) |=> !done || $past(done));

endmodule

bind ecc_stream_gen ecc_stream_gen_chk #(
    .FULL_IDX_W(FULL_IDX_W),
    .CODE_W    (CODE_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .rearm   (rearm),
    .ecc1    (ecc1),
    .ecc2    (ecc2),
    .done    (done)
);

// File: tb/ecc_stream_gen_tb.sv
module ecc_stream_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        mode_whole = 1'b0;
    logic        rearm = 1'b0;
    logic [23:0] ecc1;
    logic [23:0] ecc2;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [7:0] data_mem [512];

    always #5 clk = ~clk;

    ecc_stream_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .mode_whole(mode_whole),
        .rearm     (rearm),
        .ecc1      (ecc1),
        .ecc2      (ecc2),
        .done      (done)
    );

    // {mode, seed}: seed 0 -> all 0xFF, seed 1 -> all 0x00, else formula
    localparam logic [8:0] VEC_TAB [8] = '{
        9'h000, 9'h100, 9'h035, 9'h135, 9'h0A7, 9'h101, 9'h05C, 9'h1C3
    };

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 512; i++) begin
            if (seed == 8'h00)      data_mem[i] = 8'hFF;
            else if (seed == 8'h01) data_mem[i] = 8'h00;
            else data_mem[i] = 8'((i * seed) ^ (i >> 2) ^ seed ^ (i >> 7));
        end
    endtask

    function automatic logic [23:0] model(input int start, input int w);
        logic [8:0]  hi = '0;
        logic [8:0]  lo = '0;
        logic [5:0]  cp = '0;
        logic [23:0] code = '1;
        for (int i = 0; i < (1 << w); i++) begin
            logic [7:0] b;
            logic       p;
            b = data_mem[start + i];
            p = ^b;
            for (int k = 0; k < w; k++) begin
                if (((i >> k) & 1) == 1) hi[k] = hi[k] ^ p;
                else                     lo[k] = lo[k] ^ p;
            end
            cp[0] = cp[0] ^ b[0] ^ b[2] ^ b[4] ^ b[6];
            cp[1] = cp[1] ^ b[1] ^ b[3] ^ b[5] ^ b[7];
            cp[2] = cp[2] ^ b[0] ^ b[1] ^ b[4] ^ b[5];
            cp[3] = cp[3] ^ b[2] ^ b[3] ^ b[6] ^ b[7];
            cp[4] = cp[4] ^ (^b[3:0]);
            cp[5] = cp[5] ^ (^b[7:4]);
        end
        for (int k = 0; k < w; k++) begin
            code[2*k]   = ~lo[k];
            code[2*k+1] = ~hi[k];
        end
        for (int j = 0; j < 6; j++) code[2*w + j] = ~cp[j];
        return code;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_rearm(input logic mode, input logic junk_valid);
        @(negedge clk);
        mode_whole = mode;
        rearm      = 1'b1;
        in_valid   = junk_valid;
        in_byte    = 8'h5A;
        @(negedge clk);
        rearm    = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic feed(input int from, input int to, input int gap);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = data_mem[i];
            if (gap > 0 && (i % 7) == 3) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [23:0] ref1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 ecc1", ecc1, 24'hFFFFFF);
        chk("R11 ecc2", ecc2, 24'hFFFFFF);
        chk("R11 done", {23'd0, done}, 24'd0);
        rst_n = 1'b1;

        // R1/R2/R6/R7/R8/R12: table of runs
        for (int v = 0; v < 8; v++) begin
            logic md;
            md = VEC_TAB[v][8];
            fill(VEC_TAB[v][7:0]);
            do_rearm(md, 1'b0);
            if (!md) begin
                feed(0, 256, v % 3);
                chk("R1 R6 ecc1 first block", ecc1, model(0, 8));
                chk("R1 ecc2 pending", ecc2, 24'hFFFFFF);
                feed(256, 512, v % 3);
                chk("R1 R6 ecc2 second block", ecc2, model(256, 8));
            end else begin
                feed(0, 512, v % 3);
                chk("R2 R7 ecc1 whole", ecc1, model(0, 9));
                chk("R2 ecc2 untouched", ecc2, 24'hFFFFFF);
            end
            chk("R5 done after page", {23'd0, done}, 24'd1);
            if (VEC_TAB[v][7:0] == 8'h00) chk("R8 erased", ecc1, 24'hFFFFFF);
        end

        // R5: done timing and R4: freeze
        fill(8'h6B);
        do_rearm(1'b0, 1'b0);
        feed(0, 511, 0);
        chk("R5 done low at 511", {23'd0, done}, 24'd0);
        feed(511, 512, 0);
        chk("R5 done high at 512", {23'd0, done}, 24'd1);
        ref1 = ecc1;
        fill(8'h91);
        feed(0, 40, 1);
        chk("R4 ecc1 frozen", ecc1, ref1);
        fill(8'h6B);
        chk("R4 ecc2 frozen", ecc2, model(256, 8));
        chk("R4 done held", {23'd0, done}, 24'd1);

        // R3: rearm mid-run, and byte with rearm dropped
        fill(8'h91);
        do_rearm(1'b1, 1'b0);
        feed(0, 100, 0);
        do_rearm(1'b1, 1'b1);
        chk("R3 clear ecc1", ecc1, 24'hFFFFFF);
        chk("R3 clear done", {23'd0, done}, 24'd0);
        fill(8'h27);
        feed(0, 512, 0);
        chk("R3 fresh count", ecc1, model(0, 9));

        // R10: mode change mid-run ignored
        fill(8'h4D);
        do_rearm(1'b0, 1'b0);
        feed(0, 10, 0);
        mode_whole = 1'b1;
        feed(10, 512, 0);
        chk("R10 ecc1 split", ecc1, model(0, 8));
        chk("R10 ecc2 split", ecc2, model(256, 8));

        // R12: long gaps give the same code
        fill(8'h35);
        do_rearm(1'b1, 1'b0);
        feed(0, 512, 4);
        chk("R12 gaps", ecc1, model(0, 9));

        // R9: single-bit flips
        fill(8'h35);
        ref1 = model(0, 8);
        data_mem[77] = data_mem[77] ^ 8'h20;
        do_rearm(1'b0, 1'b0);
        feed(0, 512, 0);
        chk("R9 split flip code", ecc1, model(0, 8));
        chk("R9 split flip weight", 24'($countones(ecc1 ^ ref1)), 24'd11);
        fill(8'h35);
        ref1 = model(0, 9);
        data_mem[300] = data_mem[300] ^ 8'h04;
        do_rearm(1'b1, 1'b0);
        feed(0, 512, 0);
        chk("R9 whole flip weight", 24'($countones(ecc1 ^ ref1)), 24'd12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule